// File: doc/BRIEF.md
# Tagged Register File with Deferred Fault Reporting

A general-purpose register file in which every register keeps a two-bit fault tag beside its data word. The execution side writes a result together with a fault code. The code is stored in the tag of the destination register, and no fault is raised at that point. A fault is reported only when a later instruction reads the tagged register through one of the two read ports. That way a speculatively hoisted operation that failed costs nothing unless its result is actually consumed.

All tags can be saved and restored as one packed word through a slow side port with a request/ready handshake. This lets a context switch carry the tags along with the data registers. A service-mode input lets interrupt handlers run without creating or tripping tags. A summary output tells the surrounding control logic that at least one live register is tagged, so that external interrupts can be held off while it is high.

Top module: `tagreg_file`

## Requirements
- R1: After reset every register reads as zero, every tag is 00, and `exc_valid`, `any_tagged` and `side_ready` are low.
- R2: A write with `wr_en` high stores `wr_data` and `wr_code` (00 none, 01 divide by zero, 10 overflow, 11 invalid) into register `wr_idx` at the clock edge. A read port with its enable high returns the stored data combinationally in the same cycle. A write with code 00 clears the tag.
- R3: With `isr_mode` low, an enabled read of a register whose tag is nonzero drives `exc_valid` high in that same cycle, with `exc_code` equal to the tag and `exc_idx` equal to the index read. An enabled read of an untagged register raises nothing.
- R4: When both read ports read tagged registers in the same cycle, only one exception is reported, and it is the one for port A.
- R5: Register 0 always reads as zero data with no tag, and a write to it changes nothing.
- R6: A read and a write of the same register in the same cycle return the old data, and raise an exception only from the old tag. The new value and tag are visible from the following cycle.
- R7: While `isr_mode` is high, a write stores its data but leaves the tag at 00 whatever `wr_code` is, and reads raise no exception even from tagged registers.
- R8: `any_tagged` is high exactly while at least one register holds a nonzero tag.
- R9: A side request is accepted at the edge where `side_req` is high and the port is idle. `side_ready` is then high for exactly one cycle: the fourth cycle, counting the cycle that starts at the accepting edge as the first. During that cycle `side_rdata` holds the tag word, with the tag of register i in bits [2i+1:2i] and bits [1:0] zero.
- R10: An accepted request with `side_write` high loads the tag word captured at acceptance into all tags, using the same bit layout, at the end of the ready cycle. Bits [1:0] are ignored. A request made while the port is busy is not accepted and produces no extra ready pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| isr_mode | input | 1 | Interrupt-service mode: tags neither set nor honoured |
| wr_en | input | 1 | Write enable |
| wr_idx | input | ADDR_W | Write register index |
| wr_data | input | DATA_W | Write data |
| wr_code | input | 2 | Fault code of the producing operation |
| rd_a_en | input | 1 | Read port A enable (consumes the register) |
| rd_a_idx | input | ADDR_W | Read port A index |
| rd_a_data | output | DATA_W | Read port A data |
| rd_b_en | input | 1 | Read port B enable |
| rd_b_idx | input | ADDR_W | Read port B index |
| rd_b_data | output | DATA_W | Read port B data |
| side_req | input | 1 | Tag-word access request |
| side_write | input | 1 | 1 = restore tags, 0 = save tags |
| side_wdata | input | 2*2^ADDR_W | Tag word to restore |
| side_ready | output | 1 | Access completes this cycle |
| side_rdata | output | 2*2^ADDR_W | Tag word, valid while side_ready |
| exc_valid | output | 1 | Deferred fault raised this cycle |
| exc_code | output | 2 | Fault code being raised |
| exc_idx | output | ADDR_W | Register whose tag raised the fault |
| any_tagged | output | 1 | Some register holds a nonzero tag |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a consuming read and a write of the same register. The bench provokes it by reading a divide-by-zero tagged register on port A while rewriting that register clean. It then expects the old data and the old fault in that cycle, and clean data with no fault on the next read. The second pair is two faulting reads at once: both ports read registers with different codes, and only the port A code and index may appear. Each expectation is queued by the driver from a reference model kept in the bench, and the monitor compares it half a cycle later.

// File: rtl/tagreg_pkg.sv
package tagreg_pkg;
  localparam int TAG_W = 2;

  typedef enum logic [TAG_W-1:0] {
    FLT_NONE  = 2'b00,
    FLT_DIVZ  = 2'b01,
    FLT_OVF   = 2'b10,
    FLT_INVAL = 2'b11
  } fault_e;
endpackage

// File: rtl/tagreg_store.sv
module tagreg_store import tagreg_pkg::*; #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16,
  localparam int NREG  = 1 << ADDR_W,
  localparam int TWW   = NREG * TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              isr_mode,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [TAG_W-1:0]  wr_code,
  input  logic              rs_commit,
  input  logic [TWW-1:0]    rs_word,
  input  logic [ADDR_W-1:0] rd_a_idx,
  input  logic [ADDR_W-1:0] rd_b_idx,
  output logic [DATA_W-1:0] rd_a_data,
  output logic [DATA_W-1:0] rd_b_data,
  output logic [TAG_W-1:0]  tag_a,
  output logic [TAG_W-1:0]  tag_b,
  output logic [TWW-1:0]    tag_word,
  output logic              any_tagged
);
  logic [DATA_W-1:0] data_w [NREG];
  logic [TAG_W-1:0]  tag_w  [NREG];

  // register 0 has no storage; its restore bits are dropped
  logic unused_rs0;
  assign unused_rs0 = ^rs_word[TAG_W-1:0];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign data_w[i] = '0;
      assign tag_w[i]  = FLT_NONE;
    end else begin : g_live
      logic              hit;
      logic [DATA_W-1:0] d_q, d_n;
      logic [TAG_W-1:0]  t_q, t_n;
      logic              d_en, t_en;

      always_comb begin
        hit  = wr_en && (wr_idx == ADDR_W'(i));
        d_en = hit;
        d_n  = wr_data;
        t_en = hit || rs_commit;
        if (rs_commit)     t_n = rs_word[i*TAG_W +: TAG_W];
        else if (isr_mode) t_n = FLT_NONE;
        else               t_n = wr_code;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          d_q <= '0;
          t_q <= FLT_NONE;
        end else begin
          if (d_en) d_q <= d_n;
          if (t_en) t_q <= t_n;
        end
      end

      assign data_w[i] = d_q;
      assign tag_w[i]  = t_q;
    end
    assign tag_word[i*TAG_W +: TAG_W] = tag_w[i];
  end

  assign rd_a_data  = data_w[rd_a_idx];
  assign rd_b_data  = data_w[rd_b_idx];
  assign tag_a      = tag_w[rd_a_idx];
  assign tag_b      = tag_w[rd_b_idx];
  assign any_tagged = |tag_word;

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx != '0) |=> (data_w[$past(wr_idx)] == $past(wr_data))); // R2
  AST_ISR_TAG_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && isr_mode && !rs_commit && wr_idx != '0) |=> (tag_w[$past(wr_idx)] == FLT_NONE)); // R7
endmodule

// File: rtl/tagreg_fault.sv
module tagreg_fault import tagreg_pkg::*; #(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              isr_mode,
  input  logic              rd_a_en,
  input  logic [ADDR_W-1:0] rd_a_idx,
  input  logic [TAG_W-1:0]  tag_a,
  input  logic              rd_b_en,
  input  logic [ADDR_W-1:0] rd_b_idx,
  input  logic [TAG_W-1:0]  tag_b,
  output logic              exc_valid,
  output logic [TAG_W-1:0]  exc_code,
  output logic [ADDR_W-1:0] exc_idx
);
  logic a_hit, b_hit;

  always_comb begin
    a_hit     = rd_a_en && (tag_a != FLT_NONE) && !isr_mode;
    b_hit     = rd_b_en && (tag_b != FLT_NONE) && !isr_mode;
    exc_valid = a_hit || b_hit;
    exc_code  = FLT_NONE;
    exc_idx   = '0;
    if (a_hit) begin
      exc_code = tag_a;
      exc_idx  = rd_a_idx;
    end else if (b_hit) begin
      exc_code = tag_b;
      exc_idx  = rd_b_idx;
    end
  end

  AST_ISR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    isr_mode |-> !exc_valid); // R7
  AST_EXC_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (rd_a_en || rd_b_en)); // R3
endmodule

// File: rtl/tagreg_side.sv
module tagreg_side #(
  parameter int TWW = 16,
  parameter int LAT = 4,
  localparam int CW = $clog2(LAT + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           side_req,
  input  logic           side_write,
  input  logic [TWW-1:0] side_wdata,
  input  logic [TWW-1:0] tag_word,
  output logic           side_ready,
  output logic [TWW-1:0] side_rdata,
  output logic           rs_commit,
  output logic [TWW-1:0] rs_word
);
  logic           busy_q, busy_n;
  logic [CW-1:0]  cnt_q, cnt_n;
  logic           wr_q;
  logic [TWW-1:0] buf_q;
  logic           accept, done;

  always_comb begin
    accept = side_req && !busy_q;
    done   = busy_q && (cnt_q == CW'(LAT));
    busy_n = busy_q;
    cnt_n  = cnt_q;
    if (accept) begin
      busy_n = 1'b1;
      cnt_n  = CW'(1);
    end else if (done) begin
      busy_n = 1'b0;
      cnt_n  = '0;
    end else if (busy_q) begin
      cnt_n  = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      wr_q   <= 1'b0;
      buf_q  <= '0;
    end else begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
      if (accept) begin
        wr_q  <= side_write;
        buf_q <= side_wdata;
      end
    end
  end

  assign side_ready = done;
  assign side_rdata = done ? tag_word : '0;
  assign rs_commit  = done && wr_q;
  assign rs_word    = buf_q;

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    side_ready |=> !side_ready); // R9
  AST_ACCEPT_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !side_ready); // R10
endmodule

// File: rtl/tagreg_file.sv
module tagreg_file import tagreg_pkg::*; #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16,
  parameter int SIDE_LAT = 4,
  localparam int NREG = 1 << ADDR_W,
  localparam int TWW  = NREG * TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              isr_mode,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [TAG_W-1:0]  wr_code,
  input  logic              rd_a_en,
  input  logic [ADDR_W-1:0] rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic              rd_b_en,
  input  logic [ADDR_W-1:0] rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              side_req,
  input  logic              side_write,
  input  logic [TWW-1:0]    side_wdata,
  output logic              side_ready,
  output logic [TWW-1:0]    side_rdata,
  output logic              exc_valid,
  output logic [TAG_W-1:0]  exc_code,
  output logic [ADDR_W-1:0] exc_idx,
  output logic              any_tagged
);
  logic [1:0]         rst_sync_q;
  logic               rst_n_s;
  logic [TAG_W-1:0]   tag_a, tag_b;
  logic [TWW-1:0]     tag_word;
  logic               rs_commit;
  logic [TWW-1:0]     rs_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  tagreg_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n_s), .isr_mode(isr_mode),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_code(wr_code),
    .rs_commit(rs_commit), .rs_word(rs_word),
    .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
    .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
    .tag_a(tag_a), .tag_b(tag_b), .tag_word(tag_word), .any_tagged(any_tagged)
  );

  tagreg_fault #(.ADDR_W(ADDR_W)) u_fault (
    .clk(clk), .rst_n(rst_n_s), .isr_mode(isr_mode),
    .rd_a_en(rd_a_en), .rd_a_idx(rd_a_idx), .tag_a(tag_a),
    .rd_b_en(rd_b_en), .rd_b_idx(rd_b_idx), .tag_b(tag_b),
    .exc_valid(exc_valid), .exc_code(exc_code), .exc_idx(exc_idx)
  );

  tagreg_side #(.TWW(TWW), .LAT(SIDE_LAT)) u_side (
    .clk(clk), .rst_n(rst_n_s),
    .side_req(side_req), .side_write(side_write), .side_wdata(side_wdata),
    .tag_word(tag_word), .side_ready(side_ready), .side_rdata(side_rdata),
    .rs_commit(rs_commit), .rs_word(rs_word)
  );

  AST_NO_TAG_NO_EXC: assert property (@(posedge clk) disable iff (!rst_n_s)
    !any_tagged |-> !exc_valid); // R8
  AST_EXC_CODE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n_s)
    exc_valid |-> (exc_code != FLT_NONE)); // R3
  AST_ZERO_REG_A: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_a_idx == '0) |-> (rd_a_data == '0)); // R5
endmodule

// File: tb/sim_tagreg_file.sv
`timescale 1ns/1ps
module sim_tagreg_file;
  localparam int AW = 3;
  localparam int DW = 16;
  localparam int NR = 1 << AW;
  localparam int TW = 2 * NR;

  logic clk = 1'b0, rst_n = 1'b0, isr_mode = 1'b0;
  logic wr_en = 1'b0; logic [AW-1:0] wr_idx = '0; logic [DW-1:0] wr_data = '0; logic [1:0] wr_code = '0;
  logic rd_a_en = 1'b0, rd_b_en = 1'b0; logic [AW-1:0] rd_a_idx = '0, rd_b_idx = '0;
  logic [DW-1:0] rd_a_data, rd_b_data;
  logic side_req = 1'b0, side_write = 1'b0; logic [TW-1:0] side_wdata = '0;
  logic side_ready; logic [TW-1:0] side_rdata;
  logic exc_valid; logic [1:0] exc_code; logic [AW-1:0] exc_idx; logic any_tagged;

  always #2.5 clk = ~clk;

  tagreg_file #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .isr_mode(isr_mode),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_code(wr_code),
    .rd_a_en(rd_a_en), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_en(rd_b_en), .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .side_req(side_req), .side_write(side_write), .side_wdata(side_wdata),
    .side_ready(side_ready), .side_rdata(side_rdata),
    .exc_valid(exc_valid), .exc_code(exc_code), .exc_idx(exc_idx), .any_tagged(any_tagged)
  );

  typedef struct { int kind; logic [31:0] exp; string rq; } item_t;
  item_t sb[$];
  int checks = 0, errors = 0;
  logic [DW-1:0] md [NR];
  logic [1:0]    mt [NR];

  function automatic logic [TW-1:0] packed_tags();
    logic [TW-1:0] w = '0;
    for (int i = 1; i < NR; i++) w[2*i +: 2] = mt[i];
    return w;
  endfunction

  function automatic logic any_model();
    return packed_tags() != '0;
  endfunction

  task automatic expect_item(input int kind, input logic [31:0] exp, input string rq);
    item_t it; it.kind = kind; it.exp = exp; it.rq = rq; sb.push_back(it);
  endtask

  // monitor: compares every queued item at the falling edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it; logic [31:0] got;
      it = sb.pop_front();
      case (it.kind)
        0: got = 32'(rd_a_data);
        1: got = 32'(rd_b_data);
        2: got = 32'({exc_valid, exc_code, exc_idx});
        3: got = 32'(any_tagged);
        4: got = 32'(side_ready);
        default: got = 32'(side_rdata);
      endcase
      checks++;
      if (got !== it.exp) begin
        errors++;
        $display("FAIL %s kind %0d actual %h expected %h", it.rq, it.kind, got, it.exp);
      end
    end
  end

  task automatic op(input bit we, input int wi, input logic [DW-1:0] wd, input logic [1:0] wc,
                    input bit ae, input int ai, input bit be, input int bi, input bit isr, input string rq);
    logic ah, bh; logic [31:0] ex;
    @(posedge clk); #1;
    wr_en = we; wr_idx = AW'(wi); wr_data = wd; wr_code = wc;
    rd_a_en = ae; rd_a_idx = AW'(ai); rd_b_en = be; rd_b_idx = AW'(bi); isr_mode = isr;
    side_req = 1'b0;
    if (ae) expect_item(0, 32'(md[ai]), rq);
    if (be) expect_item(1, 32'(md[bi]), rq);
    ah = ae && mt[ai] != 0 && !isr;
    bh = be && mt[bi] != 0 && !isr;
    if (ah)      ex = 32'({1'b1, mt[ai], AW'(ai)});
    else if (bh) ex = 32'({1'b1, mt[bi], AW'(bi)});
    else         ex = '0;
    expect_item(2, ex, rq);
    expect_item(3, 32'(any_model()), "R8");
    if (we && wi != 0) begin
      md[wi] = wd;
      mt[wi] = isr ? 2'b00 : wc;
    end
  endtask

  task automatic side_op(input bit w, input logic [TW-1:0] word, input bit hold, input string rq);
    @(posedge clk); #1;
    wr_en = 0; rd_a_en = 0; rd_b_en = 0; isr_mode = 0;
    side_req = 1; side_write = w; side_wdata = word;
    expect_item(4, 0, rq);
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #1;
      if (!hold || k == 3) side_req = 0;
      expect_item(4, (k == 3) ? 1 : 0, rq);
      if (k == 3) expect_item(5, 32'(packed_tags()), "R9");
    end
    if (w) for (int i = 1; i < NR; i++) mt[i] = word[2*i +: 2];
    @(posedge clk); #1;
    side_req = 0;
    expect_item(4, 0, rq);
    expect_item(3, 32'(any_model()), "R8");
  endtask

  bit done = 0;
  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NR; i++) begin md[i] = '0; mt[i] = '0; end
    // R1: reset state while held in reset
    repeat (2) @(posedge clk); #1;
    expect_item(2, 0, "R1"); expect_item(3, 0, "R1"); expect_item(4, 0, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    for (int i = 0; i < NR; i += 2) op(0, 0, 0, 0, 1, i, 1, i + 1, 0, "R1");
    // R2: writes with each fault code
    op(1, 1, 16'h1111, 2'b00, 0, 0, 0, 0, 0, "R2");
    op(1, 2, 16'h2222, 2'b01, 0, 0, 0, 0, 0, "R2");
    op(1, 3, 16'h3333, 2'b10, 0, 0, 0, 0, 0, "R2");
    op(1, 4, 16'h4444, 2'b11, 0, 0, 0, 0, 0, "R2");
    op(1, 5, 16'h5555, 2'b00, 1, 1, 1, 5, 0, "R2");
    op(0, 0, 0, 0, 1, 5, 0, 0, 0, "R2");
    // R3: consuming reads of tagged registers
    op(0, 0, 0, 0, 1, 2, 0, 0, 0, "R3");
    op(0, 0, 0, 0, 1, 1, 1, 3, 0, "R3");
    // R4: both ports tagged, port A wins
    op(0, 0, 0, 0, 1, 4, 1, 2, 0, "R4");
    op(0, 0, 0, 0, 1, 3, 1, 4, 0, "R4");
    // R5: register 0 discards writes
    op(1, 0, 16'hFFFF, 2'b11, 0, 0, 0, 0, 0, "R5");
    op(0, 0, 0, 0, 1, 0, 1, 0, 0, "R5");
    // R6: read and write same register, same cycle
    op(1, 2, 16'hAAAA, 2'b00, 1, 2, 0, 0, 0, "R6");
    op(0, 0, 0, 0, 1, 2, 1, 2, 0, "R6");
    // R7: service mode
    op(1, 6, 16'h6666, 2'b11, 1, 3, 1, 4, 1, "R7");
    op(0, 0, 0, 0, 1, 6, 0, 0, 0, "R7");
    // R9: save
    side_op(0, '0, 0, "R9");
    // R10: restore with req held while busy, reg 0 bits ignored
    side_op(1, 16'h0403, 1, "R10");
    op(0, 0, 0, 0, 1, 5, 1, 4, 0, "R10");
    op(0, 0, 0, 0, 1, 0, 1, 3, 0, "R10");
    // R8: clear all tags, flag drops
    side_op(1, '0, 0, "R8");
    op(0, 0, 0, 0, 1, 5, 1, 6, 0, "R8");
    op(0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule